// File: doc/BRIEF.md
# Statistical Operation Sampling Selector

This block picks single operations out of a decode stream so that their progress through the pipeline can be profiled. A down-counter is decremented on every cycle that decode delivers an operation. When the count runs out, the operation decoded in that cycle becomes the sampled one. The counter then reloads with a base interval plus a pseudo-random offset. The offset keeps the selection from landing on the same instruction of a tight loop on every pass.

Only one sampled operation can be outstanding. The block follows it through three milestone indications from the pipeline: dispatch, issue and complete. It counts the cycles from dispatch to issue and from dispatch to complete. When the retire indication arrives, a latency filter decides whether the sample is reported or silently dropped. Any expiry that falls while a sample is outstanding is counted as a collision, and no operation is selected for it. The milestone and retire inputs are assumed to already be qualified for the tracked operation.

Top module: `sos_sampler`

## Requirements
- R1: After a synchronous reset the tracker is idle and all output pulses are low. The first selection comes on exactly the cfg_interval-th decode-valid cycle.
- R2: The counter changes only on cycles where enable and dec_valid are both high. The expiring decode yields sel_pulse on the next clock edge.
- R3: Each reload value is cfg_interval plus (L & ((1 << min(cfg_jitter_w, CNT_W)) - 1)), where L is the low CNT_W bits of a 16-bit LFSR. A reload value of 0 is replaced by 1. The LFSR starts at SEED and shifts left once per expiry, taking in the XOR of bits 15, 13, 12 and 10.
- R4: At most one operation is tracked, and busy stays high from selection until retire. An expiry while busy raises collision_pulse instead of sel_pulse, and the counter reloads as normal.
- R5: The sample reports dispatch-to-issue and dispatch-to-complete latencies. Each is the number of clock edges from the dispatch edge to the milestone edge. A milestone in the same cycle as dispatch gives 0.
- R6: Both latency counts saturate at 2^LAT_W-1 and do not wrap.
- R7: On retire, exactly one of sample_valid or sample_drop pulses for one cycle, and the two latency outputs are latched. The sample is kept when cfg_filter_en is 0, or when dispatch-to-complete >= cfg_min_latency.
- R8: With enable low, the counter holds its value. An in-flight sample is abandoned with no report, and no selection happens.
- R9: Milestone and retire pulses while idle have no effect. Dispatch is taken only once per sample, and retire takes priority over a milestone in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Sampling enable |
| cfg_interval | input | CNT_W | Base sampling interval in decoded operations |
| cfg_jitter_w | input | JW_W | Number of random low bits added on reload |
| cfg_filter_en | input | 1 | Enables the latency filter |
| cfg_min_latency | input | LAT_W | Minimum dispatch-to-complete latency to keep a sample |
| dec_valid | input | 1 | An operation completed decode this cycle |
| op_dispatch | input | 1 | Tracked operation dispatched |
| op_issue | input | 1 | Tracked operation issued |
| op_complete | input | 1 | Tracked operation completed |
| op_retire | input | 1 | Tracked operation retired |
| sel_pulse | output | 1 | An operation was selected for sampling |
| collision_pulse | output | 1 | Expiry lost because a sample was in flight |
| busy | output | 1 | A sample is being tracked |
| sample_valid | output | 1 | Retired sample passed the filter |
| sample_drop | output | 1 | Retired sample was discarded by the filter |
| sample_d2i | output | LAT_W | Latched dispatch-to-issue cycles |
| sample_d2c | output | LAT_W | Latched dispatch-to-complete cycles |

## Verification
A wrong counter or LFSR state shows up at sel_pulse or collision_pulse no later than the next expiry. A drifted reload sequence shifts every later selection, so a cycle-accurate reference model catches it within one interval. Tracker state errors appear on busy at the following edge. Latency counter errors are hidden until retire and then show in the latched sample outputs and in the valid/drop choice. For that reason, every random sample is driven through to retire and compared there.

// File: rtl/sos_pkg.sv
package sos_pkg;

  typedef enum logic [1:0] {
    TRK_IDLE   = 2'd0,
    TRK_ARMED  = 2'd1,
    TRK_FLIGHT = 2'd2
  } trk_state_e;

  // 16-bit maximal-length shift register, feedback from bits 15,13,12,10
  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    logic fb;
    fb = s[15] ^ s[13] ^ s[12] ^ s[10];
    return {s[14:0], fb};
  endfunction

endpackage

// File: rtl/sos_interval.sv
module sos_interval #(
  parameter int          CNT_W = 12,
  parameter int          JW_W  = 4,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             dec_valid,
  input  logic [CNT_W-1:0] cfg_interval,
  input  logic [JW_W-1:0]  cfg_jitter_w,
  output logic             expire_o
);
  localparam int CW1 = CNT_W + 1;

  logic [CNT_W:0] cnt_q;
  logic [15:0]    lfsr_q;
  logic [CNT_W:0] reload_w;

  function automatic logic [CNT_W:0] reload_value(
    input logic [CNT_W-1:0] iv,
    input logic [15:0]      l,
    input logic [JW_W-1:0]  jw
  );
    int unsigned    jwc;
    logic [CNT_W:0] mask;
    logic [CNT_W:0] r;
    jwc  = (int'(jw) > CNT_W) ? CNT_W : int'(jw);
    mask = (CW1'(1) << jwc) - CW1'(1);
    r    = {1'b0, iv} + (CW1'(l) & mask);
    if (r == '0) r = CW1'(1);
    return r;
  endfunction

  assign reload_w = reload_value(cfg_interval, lfsr_q, cfg_jitter_w);
  assign expire_o = enable && dec_valid && (cnt_q <= CW1'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= {1'b0, cfg_interval};
      lfsr_q <= SEED;
    end else if (enable && dec_valid) begin
      if (expire_o) begin
        cnt_q  <= reload_w;
        lfsr_q <= sos_pkg::lfsr_step(lfsr_q);
      end else begin
        cnt_q <= cnt_q - CW1'(1);
      end
    end
  end

endmodule

// File: rtl/sos_lat_counter.sv
module sos_lat_counter #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             load_done_i,
  input  logic             active_i,
  input  logic             stop_i,
  output logic [LAT_W-1:0] val_o
);
  localparam logic [LAT_W-1:0] MAXV = '1;

  logic done_q;

  function automatic logic [LAT_W-1:0] sat_inc(input logic [LAT_W-1:0] v);
    return (v == MAXV) ? MAXV : v + LAT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      val_o  <= '0;
      done_q <= 1'b0;
    end else if (load_i) begin
      val_o  <= '0;
      done_q <= load_done_i;
    end else if (active_i && !done_q) begin
      val_o <= sat_inc(val_o);
      if (stop_i) done_q <= 1'b1;
    end
  end

endmodule

// File: rtl/sos_tracker.sv
module sos_tracker #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             expire_i,
  input  logic             cfg_filter_en,
  input  logic [LAT_W-1:0] cfg_min_latency,
  input  logic             op_dispatch,
  input  logic             op_issue,
  input  logic             op_complete,
  input  logic             op_retire,
  output logic             busy_o,
  output logic             sel_evt_o,
  output logic             coll_evt_o,
  output logic [LAT_W-1:0] d2i_o,
  output logic [LAT_W-1:0] d2c_o,
  output logic             sel_pulse,
  output logic             collision_pulse,
  output logic             sample_valid,
  output logic             sample_drop,
  output logic [LAT_W-1:0] sample_d2i,
  output logic [LAT_W-1:0] sample_d2c
);
  import sos_pkg::*;

  localparam int NLAT = 2;

  trk_state_e       state_q;
  logic             retire_evt;
  logic             disp_evt;
  logic             active;
  logic             keep;
  logic [NLAT-1:0]  stop_vec;
  logic [LAT_W-1:0] lat_val [NLAT];

  function automatic logic filter_keep(
    input logic             fen,
    input logic [LAT_W-1:0] lat,
    input logic [LAT_W-1:0] min_lat
  );
    return !fen || (lat >= min_lat);
  endfunction

  assign busy_o     = (state_q != TRK_IDLE);
  assign sel_evt_o  = expire_i && !busy_o;
  assign coll_evt_o = expire_i && busy_o;
  assign retire_evt = enable && busy_o && op_retire;
  assign disp_evt   = enable && (state_q == TRK_ARMED) && op_dispatch && !op_retire;
  assign active     = enable && (state_q == TRK_FLIGHT) && !op_retire;
  assign stop_vec   = {op_complete, op_issue};
  assign d2i_o      = lat_val[0];
  assign d2c_o      = lat_val[1];
  assign keep       = filter_keep(cfg_filter_en, d2c_o, cfg_min_latency);

  for (genvar k = 0; k < NLAT; k++) begin : g_lat
    sos_lat_counter #(.LAT_W(LAT_W)) u_cnt (
      .clk         (clk),
      .rst         (rst),
      .load_i      (sel_evt_o || disp_evt),
      .load_done_i (disp_evt && stop_vec[k]),
      .active_i    (active),
      .stop_i      (stop_vec[k]),
      .val_o       (lat_val[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TRK_IDLE;
    end else if (!enable || retire_evt) begin
      state_q <= TRK_IDLE;
    end else if (sel_evt_o) begin
      state_q <= TRK_ARMED;
    end else if (disp_evt) begin
      state_q <= TRK_FLIGHT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_pulse       <= 1'b0;
      collision_pulse <= 1'b0;
      sample_valid    <= 1'b0;
      sample_drop     <= 1'b0;
      sample_d2i      <= '0;
      sample_d2c      <= '0;
    end else begin
      sel_pulse       <= sel_evt_o;
      collision_pulse <= coll_evt_o;
      sample_valid    <= retire_evt && keep;
      sample_drop     <= retire_evt && !keep;
      if (retire_evt) begin
        sample_d2i <= d2i_o;
        sample_d2c <= d2c_o;
      end
    end
  end

endmodule

// File: rtl/sos_sampler.sv
module sos_sampler #(
  parameter int          CNT_W = 12,
  parameter int          LAT_W = 8,
  parameter logic [15:0] SEED  = 16'hACE1,
  localparam int         JW_W  = $clog2(CNT_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [CNT_W-1:0] cfg_interval,
  input  logic [JW_W-1:0]  cfg_jitter_w,
  input  logic             cfg_filter_en,
  input  logic [LAT_W-1:0] cfg_min_latency,
  input  logic             dec_valid,
  input  logic             op_dispatch,
  input  logic             op_issue,
  input  logic             op_complete,
  input  logic             op_retire,
  output logic             sel_pulse,
  output logic             collision_pulse,
  output logic             busy,
  output logic             sample_valid,
  output logic             sample_drop,
  output logic [LAT_W-1:0] sample_d2i,
  output logic [LAT_W-1:0] sample_d2c
);
  // named internal events, observed by the bound checker
  logic             expire_w;
  logic             sel_evt_w;
  logic             coll_evt_w;
  logic [LAT_W-1:0] d2i_w;
  logic [LAT_W-1:0] d2c_w;

  sos_interval #(.CNT_W(CNT_W), .JW_W(JW_W), .SEED(SEED)) u_interval (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .dec_valid    (dec_valid),
    .cfg_interval (cfg_interval),
    .cfg_jitter_w (cfg_jitter_w),
    .expire_o     (expire_w)
  );

  sos_tracker #(.LAT_W(LAT_W)) u_tracker (
    .clk             (clk),
    .rst             (rst),
    .enable          (enable),
    .expire_i        (expire_w),
    .cfg_filter_en   (cfg_filter_en),
    .cfg_min_latency (cfg_min_latency),
    .op_dispatch     (op_dispatch),
    .op_issue        (op_issue),
    .op_complete     (op_complete),
    .op_retire       (op_retire),
    .busy_o          (busy),
    .sel_evt_o       (sel_evt_w),
    .coll_evt_o      (coll_evt_w),
    .d2i_o           (d2i_w),
    .d2c_o           (d2c_w),
    .sel_pulse       (sel_pulse),
    .collision_pulse (collision_pulse),
    .sample_valid    (sample_valid),
    .sample_drop     (sample_drop),
    .sample_d2i      (sample_d2i),
    .sample_d2c      (sample_d2c)
  );

endmodule

// File: rtl/sos_sampler_checker.sv
module sos_sampler_checker #(
  parameter int LAT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             cfg_filter_en,
  input logic [LAT_W-1:0] cfg_min_latency,
  input logic             expire_w,
  input logic             busy,
  input logic             sel_pulse,
  input logic             collision_pulse,
  input logic             sample_valid,
  input logic             sample_drop,
  input logic [LAT_W-1:0] sample_d2c,
  input logic [LAT_W-1:0] d2i_w,
  input logic [LAT_W-1:0] d2c_w
);
  localparam logic [LAT_W-1:0] MAXV = '1;

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_expiry_reported_R2: assert property (@(posedge clk) disable iff (rst)
    expire_w |=> (sel_pulse || collision_pulse));

  assert_sel_coll_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(sel_pulse && collision_pulse));

  assert_sel_sets_busy_R4: assert property (@(posedge clk) disable iff (rst)
    sel_pulse |-> busy);

  assert_coll_only_when_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && collision_pulse) |-> $past(busy));

  assert_d2i_saturates_R6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && busy && $past(busy) && $past(d2i_w) == MAXV) |-> d2i_w == MAXV);

  assert_d2c_saturates_R6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && busy && $past(busy) && $past(d2c_w) == MAXV) |-> d2c_w == MAXV);

  assert_keep_drop_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(sample_valid && sample_drop));

  assert_kept_meets_filter_R7: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && cfg_filter_en) |-> sample_d2c >= cfg_min_latency);

  assert_retire_frees_tracker_R7: assert property (@(posedge clk) disable iff (rst)
    (sample_valid || sample_drop) |-> !busy);

  assert_disable_idles_R8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !busy);

  assert_disable_no_select_R8: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(enable)) |-> !sel_pulse);

endmodule

bind sos_sampler sos_sampler_checker #(.LAT_W(LAT_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .enable          (enable),
  .cfg_filter_en   (cfg_filter_en),
  .cfg_min_latency (cfg_min_latency),
  .expire_w        (expire_w),
  .busy            (busy),
  .sel_pulse       (sel_pulse),
  .collision_pulse (collision_pulse),
  .sample_valid    (sample_valid),
  .sample_drop     (sample_drop),
  .sample_d2c      (sample_d2c),
  .d2i_w           (d2i_w),
  .d2c_w           (d2c_w)
);

// File: tb/sos_sampler_test.sv
module sos_sampler_test;
  localparam int          CNT_W = 12;
  localparam int          LAT_W = 8;
  localparam logic [15:0] SEED  = 16'hACE1;
  localparam int          JW_W  = $clog2(CNT_W + 1);
  localparam int          LMAX  = (1 << LAT_W) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst = 1'b1, enable = 1'b0, cfg_filter_en = 1'b0;
  logic [CNT_W-1:0] cfg_interval = '0;
  logic [JW_W-1:0]  cfg_jitter_w = '0;
  logic [LAT_W-1:0] cfg_min_latency = '0;
  logic dec_valid = 0, op_dispatch = 0, op_issue = 0, op_complete = 0, op_retire = 0;
  logic sel_pulse, collision_pulse, busy, sample_valid, sample_drop;
  logic [LAT_W-1:0] sample_d2i, sample_d2c;

  sos_sampler #(.CNT_W(CNT_W), .LAT_W(LAT_W), .SEED(SEED)) uut (
    .clk(clk), .rst(rst), .enable(enable), .cfg_interval(cfg_interval),
    .cfg_jitter_w(cfg_jitter_w), .cfg_filter_en(cfg_filter_en),
    .cfg_min_latency(cfg_min_latency), .dec_valid(dec_valid),
    .op_dispatch(op_dispatch), .op_issue(op_issue), .op_complete(op_complete),
    .op_retire(op_retire), .sel_pulse(sel_pulse), .collision_pulse(collision_pulse),
    .busy(busy), .sample_valid(sample_valid), .sample_drop(sample_drop),
    .sample_d2i(sample_d2i), .sample_d2c(sample_d2c));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference state, built from the requirements
  int        m_cnt, m_st, m_d2i, m_d2c, m_oi, m_oc;
  bit        m_di, m_dc, m_sel, m_coll, m_sv, m_sd;
  logic [15:0] m_lfsr;

  function automatic logic [15:0] ref_lfsr(input logic [15:0] s);
    return {s[14:0], ^(s & 16'hB400)};
  endfunction

  function automatic int ref_reload(input int iv, input int jw, input logic [15:0] l);
    int w, r;
    w = (jw > CNT_W) ? CNT_W : jw;
    r = iv + (int'(l) % (1 << w));
    return (r == 0) ? 1 : r;
  endfunction

  function automatic int ref_sat(input int v);
    return (v >= LMAX) ? LMAX : v + 1;
  endfunction

  task automatic model_update();
    bit exp_now, was_busy, keep;
    if (rst) begin
      m_cnt = int'(cfg_interval); m_lfsr = SEED; m_st = 0;
      m_d2i = 0; m_d2c = 0; m_di = 0; m_dc = 0; m_oi = 0; m_oc = 0;
      m_sel = 0; m_coll = 0; m_sv = 0; m_sd = 0;
      return;
    end
    m_sel = 0; m_coll = 0; m_sv = 0; m_sd = 0;
    if (!enable) begin m_st = 0; return; end
    exp_now  = dec_valid && (m_cnt <= 1);
    was_busy = (m_st != 0);
    if (was_busy && op_retire) begin
      keep = !cfg_filter_en || (m_d2c >= int'(cfg_min_latency));
      m_sv = keep; m_sd = !keep; m_oi = m_d2i; m_oc = m_d2c; m_st = 0;
    end else if (m_st == 1 && op_dispatch) begin
      m_st = 2; m_d2i = 0; m_d2c = 0; m_di = op_issue; m_dc = op_complete;
    end else if (m_st == 2) begin
      if (!m_di) begin m_d2i = ref_sat(m_d2i); if (op_issue) m_di = 1; end
      if (!m_dc) begin m_d2c = ref_sat(m_d2c); if (op_complete) m_dc = 1; end
    end else if (m_st == 0 && exp_now) begin
      m_sel = 1; m_st = 1; m_d2i = 0; m_d2c = 0; m_di = 0; m_dc = 0;
    end
    if (exp_now && was_busy) m_coll = 1;
    if (dec_valid) begin
      if (exp_now) begin
        m_cnt  = ref_reload(int'(cfg_interval), int'(cfg_jitter_w), m_lfsr);
        m_lfsr = ref_lfsr(m_lfsr);
      end else m_cnt = m_cnt - 1;
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    check(sel_pulse == m_sel, "R2/R3", "sel_pulse", int'(sel_pulse), int'(m_sel));
    check(collision_pulse == m_coll, "R4", "collision_pulse", int'(collision_pulse), int'(m_coll));
    check(busy == (m_st != 0), "R4", "busy", int'(busy), int'(m_st != 0));
    check(sample_valid == m_sv, "R7", "sample_valid", int'(sample_valid), int'(m_sv));
    check(sample_drop == m_sd, "R7", "sample_drop", int'(sample_drop), int'(m_sd));
    check(int'(sample_d2i) == m_oi, "R5", "sample_d2i", int'(sample_d2i), m_oi);
    check(int'(sample_d2c) == m_oc, "R5", "sample_d2c", int'(sample_d2c), m_oc);
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    #1;
    compare();
  endtask

  task automatic drive(input bit d, input bit dp, input bit is, input bit cp, input bit rt);
    dec_valid = d; op_dispatch = dp; op_issue = is; op_complete = cp; op_retire = rt;
  endtask

  task automatic do_reset();
    rst = 1'b1; drive(0, 0, 0, 0, 0);
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic run_random(input int n, input int iv, input int jw,
                            input bit fen, input int mn);
    cfg_interval = CNT_W'(iv); cfg_jitter_w = JW_W'(jw);
    cfg_filter_en = fen; cfg_min_latency = LAT_W'(mn);
    for (int i = 0; i < n; i++) begin
      enable = ($urandom % 200) != 0;
      drive(($urandom % 3) != 0, ($urandom % 4) == 0, ($urandom % 4) == 0,
            ($urandom % 6) == 0, ($urandom % 12) == 0);
      tick();
    end
  endtask

  initial begin
    int sels;
    void'($urandom(32'd20240611));
    // R1: reset state
    cfg_interval = 12'd5; cfg_jitter_w = '0; enable = 1'b1;
    do_reset();
    check(!busy && !sel_pulse && !sample_valid && !sample_drop && !collision_pulse,
          "R1", "idle after reset", int'(busy), 0);

    // R1/R2: fifth decode selects; non-decode cycles do not count
    sels = 0;
    for (int i = 0; i < 9; i++) begin
      drive(i % 2 == 0, 0, 0, 0, 0);
      tick();
      if (i < 8) sels += int'(sel_pulse);
    end
    check(sels == 0 && sel_pulse, "R2", "select on 5th decode", sels, 0);

    // R9: dispatch taken once; R5 latencies
    drive(0, 1, 0, 0, 0); tick();
    drive(0, 1, 0, 0, 0); tick();
    drive(0, 0, 1, 0, 0); tick();
    drive(0, 0, 0, 0, 0); tick();
    drive(0, 0, 0, 1, 0); tick();
    drive(0, 0, 0, 0, 1); tick();
    check(sample_valid && sample_d2i == 8'd2 && sample_d2c == 8'd4, "R5",
          "latencies 2/4", int'(sample_d2c), 4);

    // R9: milestones while idle are ignored
    drive(0, 1, 1, 1, 1); tick(); tick();
    check(!busy && !sample_valid && !sample_drop, "R9", "idle pulses ignored",
          int'(busy), 0);

    // R4: interval 1, back-to-back decodes collide
    cfg_interval = 12'd1; do_reset();
    drive(1, 0, 0, 0, 0); tick();
    check(sel_pulse, "R4", "first select", int'(sel_pulse), 1);
    tick();
    check(collision_pulse && !sel_pulse && busy, "R4", "collision while busy",
          int'(collision_pulse), 1);

    // R8: disable abandons the sample silently
    drive(0, 0, 0, 0, 0); enable = 1'b0; tick();
    check(!busy, "R8", "busy cleared by disable", int'(busy), 0);
    drive(1, 0, 0, 0, 1); tick(); tick();
    check(!sel_pulse && !sample_valid && !sample_drop, "R8", "no activity disabled",
          int'(sel_pulse), 0);
    enable = 1'b1;

    // R6: saturation of both latencies
    cfg_interval = 12'd2; do_reset();
    drive(1, 0, 0, 0, 0); tick(); tick();
    drive(0, 1, 0, 0, 0); tick();
    drive(0, 0, 0, 0, 0);
    for (int i = 0; i < 300; i++) tick();
    drive(0, 0, 1, 1, 0); tick();
    drive(0, 0, 0, 0, 1); tick();
    check(sample_d2i == 8'd255 && sample_d2c == 8'd255, "R6", "saturated",
          int'(sample_d2i), 255);

    // R7: filter drops a short sample, keeps it when threshold is met
    cfg_filter_en = 1'b1; cfg_min_latency = 8'd10;
    drive(1, 0, 0, 0, 0); tick(); tick();
    drive(0, 1, 0, 0, 0); tick();
    drive(0, 0, 1, 1, 0); tick();
    drive(0, 0, 0, 0, 1); tick();
    check(sample_drop && !sample_valid && sample_d2c == 8'd1, "R7", "dropped",
          int'(sample_drop), 1);
    cfg_min_latency = 8'd1;
    drive(1, 0, 0, 0, 0); tick(); tick();
    drive(0, 1, 0, 0, 0); tick();
    drive(0, 0, 1, 1, 0); tick();
    drive(0, 0, 0, 0, 1); tick();
    check(sample_valid && !sample_drop, "R7", "kept at threshold",
          int'(sample_valid), 1);

    // R3: random runs with perturbation, width clamp and filter
    do_reset();
    run_random(4000, 7, 3, 1'b0, 0);
    run_random(4000, 0, 15, 1'b1, 6);
    cfg_interval = 12'd3; do_reset();
    run_random(4000, 3, 1, 1'b1, 3);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule